// File: doc/BRIEF.md
# Page ECC generator with readout

This block sits beside a NAND data path and builds a single-error-correcting Hamming code over the bytes that pass through it. It keeps one parity accumulator for each 256-byte chunk of a page. Each chunk produces three check bytes: two bytes of line parity over the byte index, and one byte of column parity over the bit position. All three are stored inverted, so a page of erased (all-ones) bytes gives all-ones check bytes.

Software drives the block through a 2-bit mode field. It selects reset, off, accumulate or readout. A page starts with reset, then off, then accumulate. Each byte accepted in accumulate mode updates the parity of the current chunk. After every 256 accepted bytes, the block moves on to the next chunk.

To collect the result, software selects off and then readout. It then pulls the check bytes one at a time through read requests, and returns to off when done. Within each chunk the bytes come out in a fixed order, and then the next chunk follows. Correcting the data on the host side is not part of this block.

Top module: `page_ecc_gen`

## Requirements
- R1: A pulse on `mode_wr` loads `mode_in` into the mode register at that clock edge. The encoding is 2'b00 off, 2'b01 accumulate, 2'b10 readout and 2'b11 reset. After `rst`, the mode is off, `rd_valid` is 0 and `rd_data` is 8'h00.
- R2: While the mode is reset, every parity accumulator, the chunk counter and the readout pointer are cleared. A readout straight after reset returns 8'hFF for every check byte.
- R3: A byte presented with `byte_valid` changes parity state only while the mode is accumulate. Bytes presented in off, readout or reset mode leave the check bytes unchanged.
- R4: Line parity uses P, the XOR of the eight bits of a byte, and its index i within the chunk (0..255). For each k in 0..7, bit 2k+1 is the XOR of P over bytes with bit k of i set. Bit 2k is the XOR of P over bytes with bit k of i clear. Check byte 0 holds the inverted bits 7..0 of this line parity. Check byte 1 holds the inverted bits 15..8.
- R5: Column parity has six bits. For each m in 0..2, bit 2m+1 is the XOR over the chunk of all data bits j with bit m of j set. Bit 2m is the XOR over the chunk of all data bits j with bit m of j clear. Check byte 2 is the inverse of {column parity bits 5..0, 2'b00}.
- R6: A chunk of 256 bytes of 8'hFF yields check bytes 8'hFF, 8'hFF, 8'hFF.
- R7: After 256 accepted bytes, the next byte goes to the next chunk's accumulator. Bytes accepted after the last chunk (CHUNKS*256 bytes) are ignored. A partly filled chunk holds the code of the bytes it has received.
- R8: Each readout request returns the next byte in this order: check byte 1, check byte 0, check byte 2 of chunk 0, then the same three for chunk 1, and so on. After the last chunk the pointer wraps to chunk 0.
- R9: `rd_valid` is high, with the byte on `rd_data`, in the cycle after a `rd_req` that was sampled in readout mode. In any other mode, `rd_req` produces no `rd_valid` and does not move the readout pointer.
- R10: If one bit (byte i, bit j) of a chunk is flipped, the XOR of the two codes behaves as a locator. Every line pair and every column pair has exactly one bit set, and the odd members spell out i and j. The two low bits of byte 2 stay clear, and the other chunks' codes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe that loads `mode_in` into the mode register |
| mode_in | input | 2 | New mode: 00 off, 01 accumulate, 10 readout, 11 reset |
| byte_valid | input | 1 | A data byte moves through the path this cycle |
| byte_in | input | 8 | The data byte |
| rd_req | input | 1 | Data-port read request |
| rd_data | output | 8 | Check byte returned for the previous read request |
| rd_valid | output | 1 | `rd_data` carries a check byte this cycle |

## Verification
A mode written at one rising edge governs the bytes and read requests sampled at the next edge. A byte accepted at an edge has updated its chunk's check bytes by the following cycle. A check byte appears on `rd_data` with `rd_valid` exactly one cycle after its `rd_req` is sampled. The bench drives every input on the falling edge, and the driver queues the expected byte as it raises `rd_req`. The monitor pops and compares at the next falling edge, and any `rd_valid` that arrives with an empty queue counts as a failure. A short drain after each readout confirms that no expected byte went missing.

// File: rtl/page_ecc_pkg.sv
`timescale 1ns/1ps
package page_ecc_pkg;
  localparam int BYTE_W      = 8;
  localparam int IDX_W       = 8;
  localparam int CHUNK_BYTES = 1 << IDX_W;
  localparam int COL_W       = 6;
  localparam int LINE_W      = 2 * IDX_W;
  localparam int CODE_BYTES  = 3;

  typedef enum logic [1:0] {
    MD_OFF  = 2'b00,
    MD_ACC  = 2'b01,
    MD_READ = 2'b10,
    MD_CLR  = 2'b11
  } mode_e;

  typedef logic [CODE_BYTES-1:0][BYTE_W-1:0] code_t;

  // Column parity of one byte: odd member of each pair covers bits whose
  // position has the selector bit set, even member the complement.
  function automatic logic [COL_W-1:0] col_bits(input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] hi_mask;
    logic [COL_W-1:0]  r;
    for (int m = 0; m < COL_W/2; m++) begin
      for (int j = 0; j < BYTE_W; j++) hi_mask[j] = ((j >> m) & 1) == 1;
      r[2*m+1] = ^(d & hi_mask);
      r[2*m]   = ^(d & ~hi_mask);
    end
    return r;
  endfunction

  // Readout order within a chunk: byte 1, byte 0, byte 2.
  function automatic logic [1:0] pick_byte(input logic [1:0] slot);
    case (slot)
      2'd0:    return 2'd1;
      2'd1:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/page_ecc_acc.sv
`timescale 1ns/1ps
module page_ecc_acc
  import page_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  output code_t             code
);
  logic [COL_W-1:0]  col_q;
  logic [IDX_W-1:0]  odd_q;
  logic              tot_q;
  logic              bpar;
  logic [LINE_W-1:0] line;

  assign bpar = ^din;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      col_q <= '0;
      odd_q <= '0;
      tot_q <= 1'b0;
    end else if (en) begin
      col_q <= col_q ^ col_bits(din);
      odd_q <= odd_q ^ ({IDX_W{bpar}} & idx);
      tot_q <= tot_q ^ bpar;
    end
  end

  // Even member of each line pair = total parity minus the odd member.
  always_comb begin
    for (int k = 0; k < IDX_W; k++) begin
      line[2*k+1] = odd_q[k];
      line[2*k]   = tot_q ^ odd_q[k];
    end
    code[0] = ~line[BYTE_W-1:0];
    code[1] = ~line[LINE_W-1:BYTE_W];
    code[2] = ~{col_q, 2'b00};
  end
endmodule

// File: rtl/page_ecc_ctr.sv
`timescale 1ns/1ps
module page_ecc_ctr
  import page_ecc_pkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int CI_W  = $clog2(CHUNKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fire,
  output logic             take,
  output logic [CI_W-1:0]  chunk_idx,
  output logic [IDX_W-1:0] byte_idx
);
  assign take = fire && (chunk_idx < CI_W'(CHUNKS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chunk_idx <= '0;
      byte_idx  <= '0;
    end else if (take) begin
      byte_idx <= byte_idx + 1'b1;
      if (byte_idx == IDX_W'(CHUNK_BYTES - 1)) chunk_idx <= chunk_idx + 1'b1;
    end
  end
endmodule

// File: rtl/page_ecc_rd.sv
`timescale 1ns/1ps
module page_ecc_rd
  import page_ecc_pkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int RC_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     step,
  input  code_t [CHUNKS-1:0]       codes,
  output logic [BYTE_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [1:0]               slot
);
  logic [RC_W-1:0] chunk;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chunk    <= '0;
      slot     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= step;
      if (step) begin
        rd_data <= codes[chunk][pick_byte(slot)];
        if (slot == 2'd2) begin
          slot  <= '0;
          chunk <= (chunk == RC_W'(CHUNKS - 1)) ? '0 : chunk + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/page_ecc_gen.sv
`timescale 1ns/1ps
module page_ecc_gen
  import page_ecc_pkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int CI_W  = $clog2(CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [1:0]        mode_in,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              rd_req,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  mode_e              mode_q;
  logic               clr;
  logic               fire;
  logic               step;
  logic               take;
  logic [CI_W-1:0]    chunk_idx;
  logic [IDX_W-1:0]   byte_idx;
  logic [1:0]         rd_sel;
  code_t [CHUNKS-1:0] codes;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= MD_OFF;
    else if (mode_wr) mode_q <= mode_e'(mode_in);
  end

  assign clr  = (mode_q == MD_CLR);
  assign fire = byte_valid && (mode_q == MD_ACC);
  assign step = rd_req && (mode_q == MD_READ);

  page_ecc_ctr #(.CHUNKS(CHUNKS)) u_ctr (
    .clk(clk), .rst(rst), .clr(clr), .fire(fire),
    .take(take), .chunk_idx(chunk_idx), .byte_idx(byte_idx)
  );

  for (genvar g = 0; g < CHUNKS; g++) begin : g_acc
    page_ecc_acc u_acc (
      .clk(clk), .rst(rst), .clr(clr),
      .en(take && (chunk_idx == CI_W'(g))),
      .idx(byte_idx), .din(byte_in), .code(codes[g])
    );
  end

  page_ecc_rd #(.CHUNKS(CHUNKS)) u_rd (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .codes(codes),
    .rd_data(rd_data), .rd_valid(rd_valid), .slot(rd_sel)
  );
endmodule

// File: rtl/page_ecc_gen_chk.sv
`timescale 1ns/1ps
module page_ecc_gen_chk #(
  parameter int CHUNKS = 2,
  localparam int CI_W  = $clog2(CHUNKS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            mode_wr,
  input logic [1:0]      mode_in,
  input logic [1:0]      mode_q,
  input logic            rd_req,
  input logic            rd_valid,
  input logic [CI_W-1:0] chunk_idx,
  input logic [1:0]      rd_sel
);
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst) mode_wr |=> (mode_q == $past(mode_in))); // R1
  AST_CLR_PTRS: assert property (@(posedge clk) disable iff (rst) (mode_q == 2'b11) |=> (chunk_idx == '0 && rd_sel == 2'd0 && !rd_valid)); // R2
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst) (mode_q == 2'b00) |=> $stable(chunk_idx)); // R3
  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (rst) chunk_idx <= CI_W'(CHUNKS)); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) rd_sel <= 2'd2); // R8
  AST_NO_READ_OUTSIDE: assert property (@(posedge clk) disable iff (rst) (mode_q != 2'b10) |=> !rd_valid); // R9
  AST_READ_ONE_LATE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(rd_req)); // R9
endmodule

bind page_ecc_gen page_ecc_gen_chk #(.CHUNKS(CHUNKS)) u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
  .mode_q(mode_q), .rd_req(rd_req), .rd_valid(rd_valid),
  .chunk_idx(chunk_idx), .rd_sel(rd_sel)
);

// File: tb/page_ecc_gen_bench.sv
`timescale 1ns/1ps
module page_ecc_gen_bench;
  localparam int CHUNKS = 2;
  localparam int PAGE   = CHUNKS * 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;

  always #2.5 clk = ~clk;

  page_ecc_gen #(.CHUNKS(CHUNKS)) u_page_ecc_gen (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in),
    .byte_valid(byte_valid), .byte_in(byte_in),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] cap[$];
  logic [7:0] page [PAGE];

  // Reference code of cnt bytes of the page starting at base.
  function automatic logic [2:0][7:0] model(int base, int cnt);
    logic [15:0] lp;
    logic [5:0]  cp;
    logic [7:0]  b;
    lp = '0;
    cp = '0;
    for (int i = 0; i < cnt; i++) begin
      b = page[base + i];
      for (int k = 0; k < 8; k++)
        if (^b) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 3; m++)
          cp[2*m + ((j >> m) & 1)] ^= b[j];
    end
    model[0] = ~lp[7:0];
    model[1] = ~lp[15:8];
    model[2] = ~{cp, 2'b00};
  endfunction

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      logic [7:0] e;
      string      t;
      cap.push_back(rd_data);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected rd_valid act=%02h exp=none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_in = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic start_page();
    set_mode(2'b11); set_mode(2'b00); set_mode(2'b01);
  endtask

  task automatic feed(input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_in = page[lo + i];
    end
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic feed_junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_in = 8'($urandom);
    end
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic read_byte(input logic [7:0] e, input string tg);
    @(negedge clk); rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tg);
  endtask

  task automatic read_chunk(input int c, input int cnt, input string tg);
    logic [2:0][7:0] e;
    e = model(c * 256, cnt);
    read_byte(e[1], {tg, " R8 byte1"});
    read_byte(e[0], {tg, " R4 byte0"});
    read_byte(e[2], {tg, " R5 byte2"});
  endtask

  task automatic finish_read();
    @(negedge clk); rd_req = 1'b0;
    set_mode(2'b00);
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing read data act=%0d exp=0 pending", exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic read_page(input int n0, input int n1, input string tg);
    set_mode(2'b00); set_mode(2'b10);
    read_chunk(0, n0, tg);
    read_chunk(1, n1, tg);
    finish_read();
  endtask

  task automatic rand_page();
    for (int i = 0; i < PAGE; i++) page[i] = 8'($urandom);
  endtask

  task automatic flip_test(input int c, input int i, input int j);
    logic [7:0] a [6];
    logic [7:0] s [3];
    logic [15:0] lp;
    logic [5:0]  cp;
    int di, dj;
    bit pairs_ok;
    rand_page();
    cap.delete();
    start_page(); feed(0, PAGE); read_page(256, 256, "R10 base");
    for (int q = 0; q < 6; q++) a[q] = cap[q];
    page[c*256 + i][j] = ~page[c*256 + i][j];
    cap.delete();
    start_page(); feed(0, PAGE); read_page(256, 256, "R10 flipped");
    for (int q = 0; q < 3; q++) s[q] = a[c*3 + q] ^ cap[c*3 + q];
    lp = {s[0], s[1]};
    cp = s[2][7:2];
    pairs_ok = (s[2][1:0] == 2'b00);
    di = 0; dj = 0;
    for (int k = 0; k < 8; k++) begin
      if (lp[2*k] == lp[2*k+1]) pairs_ok = 1'b0;
      di |= int'(lp[2*k+1]) << k;
    end
    for (int m = 0; m < 3; m++) begin
      if (cp[2*m] == cp[2*m+1]) pairs_ok = 1'b0;
      dj |= int'(cp[2*m+1]) << m;
    end
    checks++;
    if (!pairs_ok || di != i || dj != j) begin
      errors++;
      $display("FAIL R10 locate act=byte%0d bit%0d pairs_ok=%0d exp=byte%0d bit%0d",
               di, dj, pairs_ok, i, j);
    end
    checks++;
    for (int q = 0; q < 3; q++)
      if (a[(1-c)*3 + q] != cap[(1-c)*3 + q]) begin
        errors++;
        $display("FAIL R10 other chunk changed act=%02h exp=%02h",
                 cap[(1-c)*3 + q], a[(1-c)*3 + q]);
      end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset state act=%0b/%02h exp=0/00", rd_valid, rd_data);
    end

    // R1 R2: readout straight after reset gives all-ones bytes
    for (int i = 0; i < PAGE; i++) page[i] = 8'h00;
    start_page();
    read_page(0, 0, "R1 R2 empty");

    // R6: erased page
    for (int i = 0; i < PAGE; i++) page[i] = 8'hFF;
    start_page(); feed(0, PAGE);
    read_page(256, 256, "R6 erased");

    // R3: bytes outside accumulate mode are ignored
    rand_page();
    set_mode(2'b11); set_mode(2'b00); feed_junk(12);
    set_mode(2'b01); feed(0, PAGE);
    set_mode(2'b00); feed_junk(9);
    set_mode(2'b10); feed_junk(5);
    read_chunk(0, 256, "R3 random");
    read_chunk(1, 256, "R3 random");
    finish_read();

    // R4 R5: another random pattern, sparse data
    for (int i = 0; i < PAGE; i++) page[i] = ($urandom % 5 == 0) ? 8'(1 << (i % 8)) : 8'h00;
    start_page(); feed(0, PAGE);
    read_page(256, 256, "R4 R5 sparse");

    // R7: bytes past the last chunk are ignored
    rand_page();
    start_page(); feed(0, PAGE); feed_junk(40);
    read_page(256, 256, "R7 overflow");

    // R7: partly filled second chunk
    rand_page();
    start_page(); feed(0, 300);
    read_page(256, 44, "R7 partial");

    // R9: rd_req outside readout mode has no effect; R8 wrap
    rand_page();
    start_page(); feed(0, PAGE);
    set_mode(2'b00);
    @(negedge clk); rd_req = 1'b1;
    repeat (3) @(negedge clk);
    rd_req = 1'b0;
    set_mode(2'b10);
    read_chunk(0, 256, "R9 after idle req");
    read_chunk(1, 256, "R9 after idle req");
    read_chunk(0, 256, "R8 wrap");
    finish_read();

    // R2: reset after accumulation clears everything
    start_page(); feed(0, 100);
    set_mode(2'b10); read_byte(model(0, 100)  [1], "R8 partial first");
    @(negedge clk); rd_req = 1'b0;
    for (int i = 0; i < PAGE; i++) page[i] = 8'h00;
    set_mode(2'b11); set_mode(2'b00);
    read_page(0, 0, "R2 cleared");

    // R10: single-bit flips located by the syndrome
    flip_test(0, 0, 0);
    flip_test(1, 255, 7);
    flip_test(0, 173, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule